// File: doc/BRIEF.md
# TFT Line Control Strobe Generator

This block drives the per-line control signals of a TFT panel whose column driver needs an output-enable strobe, a polarity signal and a common-electrode signal at programmed points along each line. It runs on the pixel clock. A line-start pulse marks pixel 0 of each line. An internal divide-by-two prescaler turns pixels into two-pixel units, and every programmed position and width is given in those units. Four 8-bit timing values and one control bit are written through a small address/data write port.

Timing values are staged when written. They are copied into the working set only on the clock edge that samples a line-start pulse, so a line always runs with one consistent set of values. The output-enable strobe is high for the programmed number of units, starting at the programmed unit. Polarity and common-electrode each invert once per line at their own programmed unit, so their levels alternate from line to line. A static control bit drives a secondary clock-enable output. Every output is active only while the 2-bit panel-type input is `2'b10`. Any other value holds all outputs low and freezes the two toggling levels.

Top module: `tft_line_ctrl`

## Requirements
- R1: During synchronous reset and directly after it, all outputs are 0 and all staged and working register values are 0.
- R2: The edge that samples `lineStart` is pixel 0. With working rise value P and a non-zero width, `oeOut` first goes high in the cycle after clock edge 2P+1 counted from that edge.
- R3: `oeOut` stays high for exactly 2W consecutive cycles, where W is the working width. W = 0 produces no pulse.
- R4: `polOut` inverts exactly once per line. The inversion becomes visible after edge 2Q+1 counted from the line-start edge, where Q is the working polarity position.
- R5: `vcomOut` inverts exactly once per line at its own working position, independently of `polOut`, with the same timing rule as R4.
- R6: When `panelType` is not `2'b10`, `oeOut`, `polOut`, `vcomOut` and `clkEnOut` are 0, and the polarity and common-electrode levels do not change.
- R7: `clkEnOut` equals bit 0 of the value at address 4 while `panelType` is `2'b10`. A write to that address shows on the output in the cycle after the write edge, without waiting for a line start.
- R8: Write addresses are: 0 = OE rise unit, 1 = OE width, 2 = polarity unit, 3 = common-electrode unit. Values written to these addresses take effect only at the next line-start edge. A write on the same edge as a line start takes effect at the line start after that one.
- R9: After reset and before the first line start, no OE pulse and no toggle occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| lineStart | input | 1 | One-cycle pulse marking pixel 0 of a line |
| panelType | input | 2 | Panel interface select; this block is active at 2'b10 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| oeOut | output | 1 | Output-enable strobe |
| polOut | output | 1 | Polarity signal |
| vcomOut | output | 1 | Common-electrode signal |
| clkEnOut | output | 1 | Static secondary clock-enable output |

## Verification
The embedded assertions check several properties on every cycle. Working values never change except at a line-start edge. A line-start edge always clears the prescaler and unit counter. A toggle strobe never fires on two consecutive cycles. A deselected panel type freezes both toggling levels. A behavioural pixel-indexed model in the bench is compared against all four outputs on every clock. The exact rise cycle, the pulse length, the once-per-line inversion and the deferral of a write that coincides with a line start can only be shown by the bench's line scenarios. These scenarios cover a mid-line rewrite, zero width, maximum positions and a deselected panel type.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  parameter int POS_W = 8;
  parameter int ADDR_W = 3;
  localparam int CNT_W = POS_W + 2;

  typedef struct packed {
    logic [POS_W-1:0] rise;
    logic [POS_W-1:0] width;
    logic [POS_W-1:0] polPos;
    logic [POS_W-1:0] vcomPos;
  } lineCfg_t;

  typedef struct packed {
    logic oeLevel;
    logic polFlip;
    logic vcomFlip;
  } lineStrobe_t;

  localparam logic [ADDR_W-1:0] ADDR_RISE  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_WIDTH = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_POL   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_VCOM  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd4;
  localparam logic [1:0]        TYPE_SEL   = 2'b10;
endpackage

// File: rtl/tlc_regbank.sv
module tlc_regbank
  import tlc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lineStart,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [POS_W-1:0]  wrData,
  output lineCfg_t          workCfg,
  output logic              clkEnBit
);
  lineCfg_t stageCfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageCfg <= '0;
      clkEnBit <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_RISE:  stageCfg.rise    <= wrData;
        ADDR_WIDTH: stageCfg.width   <= wrData;
        ADDR_POL:   stageCfg.polPos  <= wrData;
        ADDR_VCOM:  stageCfg.vcomPos <= wrData;
        ADDR_CTRL:  clkEnBit         <= wrData[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) workCfg <= '0;
    else if (lineStart) workCfg <= stageCfg;
  end

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !lineStart |=> $stable(workCfg));
endmodule

// File: rtl/tlc_ctrl.sv
module tlc_ctrl
  import tlc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        lineStart,
  input  lineCfg_t    workCfg,
  output lineStrobe_t strb
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] unitCnt;
  logic             phase;
  logic             active;
  logic [CNT_W-1:0] riseExt, endExt, polExt, vcomExt;

  always_ff @(posedge clk) begin
    if (rst) begin
      unitCnt <= CNT_MAX;
      phase   <= 1'b0;
    end else if (lineStart) begin
      unitCnt <= '0;
      phase   <= 1'b0;
    end else if (unitCnt != CNT_MAX) begin
      phase <= ~phase;
      if (phase) unitCnt <= unitCnt + 1'b1;
    end
  end

  always_comb begin
    active  = (unitCnt != CNT_MAX);
    riseExt = CNT_W'(workCfg.rise);
    endExt  = CNT_W'(workCfg.rise) + CNT_W'(workCfg.width);
    polExt  = CNT_W'(workCfg.polPos);
    vcomExt = CNT_W'(workCfg.vcomPos);
    strb.oeLevel  = active && (unitCnt >= riseExt) && (unitCnt < endExt);
    strb.polFlip  = active && !phase && (unitCnt == polExt);
    strb.vcomFlip = active && !phase && (unitCnt == vcomExt);
  end

  // R2
  line_origin_chk: assert property (@(posedge clk) disable iff (rst)
    lineStart |=> (unitCnt == '0) && !phase);
  // R4
  pol_single_chk: assert property (@(posedge clk) disable iff (rst)
    strb.polFlip |=> !strb.polFlip);
  // R5
  vcom_single_chk: assert property (@(posedge clk) disable iff (rst)
    strb.vcomFlip |=> !strb.vcomFlip);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !active |-> !strb.oeLevel && !strb.polFlip && !strb.vcomFlip);
endmodule

// File: rtl/tlc_out.sv
module tlc_out
  import tlc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        typeSel,
  input  logic        clkEnBit,
  input  lineStrobe_t strb,
  output logic        oeOut,
  output logic        polOut,
  output logic        vcomOut,
  output logic        clkEnOut
);
  logic oeState, polState, vcomState;

  always_ff @(posedge clk) begin
    if (rst) begin
      oeState   <= 1'b0;
      polState  <= 1'b0;
      vcomState <= 1'b0;
    end else begin
      oeState   <= strb.oeLevel & typeSel;
      polState  <= polState  ^ (strb.polFlip  & typeSel);
      vcomState <= vcomState ^ (strb.vcomFlip & typeSel);
    end
  end

  assign oeOut    = oeState   & typeSel;
  assign polOut   = polState  & typeSel;
  assign vcomOut  = vcomState & typeSel;
  assign clkEnOut = clkEnBit  & typeSel;

  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !typeSel |=> $stable(polState) && $stable(vcomState));
  // R3
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    oeState |-> $past(typeSel));
endmodule

// File: rtl/tft_line_ctrl.sv
module tft_line_ctrl
  import tlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lineStart,
  input  logic [1:0] panelType,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       oeOut,
  output logic       polOut,
  output logic       vcomOut,
  output logic       clkEnOut
);
  lineCfg_t    workCfg;
  lineStrobe_t strb;
  logic        clkEnBit;
  logic        typeSel;

  assign typeSel = (panelType == TYPE_SEL);

  tlc_regbank regs_i (
    .clk(clk), .rst(rst), .lineStart(lineStart),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .workCfg(workCfg), .clkEnBit(clkEnBit)
  );

  tlc_ctrl ctrl_i (
    .clk(clk), .rst(rst), .lineStart(lineStart),
    .workCfg(workCfg), .strb(strb)
  );

  tlc_out out_i (
    .clk(clk), .rst(rst), .typeSel(typeSel), .clkEnBit(clkEnBit),
    .strb(strb), .oeOut(oeOut), .polOut(polOut),
    .vcomOut(vcomOut), .clkEnOut(clkEnOut)
  );
endmodule

// File: tb/tft_line_ctrl_tb.sv
module tft_line_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lineStart = 1'b0;
  logic [1:0] panelType = 2'b10;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic oeOut, polOut, vcomOut, clkEnOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  tft_line_ctrl dut_i (
    .clk(clk), .rst(rst), .lineStart(lineStart), .panelType(panelType),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .oeOut(oeOut), .polOut(polOut), .vcomOut(vcomOut), .clkEnOut(clkEnOut)
  );

  // behavioural reference: pixel index since line start
  int px = -1;
  int sR = 0, sW = 0, sP = 0, sV = 0, sC = 0;
  int wR = 0, wW = 0, wP = 0, wV = 0;
  bit exOe = 0, exPol = 0, exVcom = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    bit ok;
    int u;
    cycles++;
    ok = (panelType == 2'b10);
    if (rst) begin
      px = -1; sR = 0; sW = 0; sP = 0; sV = 0; sC = 0;
      wR = 0; wW = 0; wP = 0; wV = 0; exOe = 0; exPol = 0; exVcom = 0;
    end else begin
      if (px >= 0) begin
        u = px / 2;
        exOe = ok && wW != 0 && u >= wR && u < wR + wW;
        if (ok && px % 2 == 0 && u == wP) exPol = !exPol;
        if (ok && px % 2 == 0 && u == wV) exVcom = !exVcom;
      end else exOe = 0;
      if (lineStart) begin
        wR = sR; wW = sW; wP = sP; wV = sV; px = 0;
      end else if (px >= 0) px++;
      if (wrEn) begin
        case (wrAddr)
          3'd0: sR = wrData;
          3'd1: sW = wrData;
          3'd2: sP = wrData;
          3'd3: sV = wrData;
          3'd4: sC = wrData[0];
          default: ;
        endcase
      end
    end
    #1;
    if (!rst) begin
      ok = (panelType == 2'b10);
      chk("R2 R3 R6 oeOut", oeOut, exOe & ok);
      chk("R4 R6 polOut", polOut, exPol & ok);
      chk("R5 R6 vcomOut", vcomOut, exVcom & ok);
      chk("R7 clkEnOut", clkEnOut, sC[0] & ok);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runLine(input int len, output int oeCnt, output int polCnt, output int vcomCnt);
    logic pp, pv;
    pp = polOut; pv = vcomOut;
    oeCnt = 0; polCnt = 0; vcomCnt = 0;
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (oeOut) oeCnt++;
      if (polOut != pp) polCnt++;
      if (vcomOut != pv) vcomCnt++;
      pp = polOut; pv = vcomOut;
      @(negedge clk);
    end
  endtask

  task automatic cnt(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    int o, p, v;
    int firstOe;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    cnt("R1 outputs in reset", {oeOut, polOut, vcomOut, clkEnOut}, 0);
    rst = 1'b0;
    @(negedge clk);
    cnt("R1 outputs after reset", {oeOut, polOut, vcomOut, clkEnOut}, 0);

    // R9: programmed but no line start yet
    wr(3'd0, 8'd0); wr(3'd1, 8'd3); wr(3'd2, 8'd0);
    repeat (20) @(negedge clk);
    cnt("R9 idle oe", {29'd0, oeOut, polOut, vcomOut}, 0);

    // R2 R3 R4 R5 R7: basic line
    wr(3'd0, 8'd3); wr(3'd1, 8'd2); wr(3'd2, 8'd5); wr(3'd3, 8'd1); wr(3'd4, 8'd1);
    cnt("R7 clkEn after write", clkEnOut, 1);
    runLine(40, o, p, v); // line carries values staged before it
    runLine(40, o, p, v);
    cnt("R3 oe width 2", o, 4);
    cnt("R4 pol once", p, 1);
    cnt("R5 vcom once", v, 1);

    // R2: locate first OE cycle
    lineStart = 1'b1; @(negedge clk); lineStart = 1'b0;
    firstOe = -1;
    for (int i = 0; i < 40; i++) begin
      if (oeOut && firstOe < 0) firstOe = i;
      @(negedge clk);
    end
    cnt("R2 oe rise pixel", firstOe, 7);

    // R8: mid-line rewrite affects only next line
    lineStart = 1'b1; @(negedge clk); lineStart = 1'b0;
    wr(3'd1, 8'd5);
    repeat (38) @(negedge clk);
    runLine(40, o, p, v);
    cnt("R8 new width applied next line", o, 10);

    // R8: write coincident with line start is deferred
    lineStart = 1'b1; wrEn = 1'b1; wrAddr = 3'd1; wrData = 8'd1;
    @(negedge clk);
    lineStart = 1'b0; wrEn = 1'b0;
    o = 0;
    for (int i = 0; i < 39; i++) begin
      if (oeOut) o++;
      @(negedge clk);
    end
    cnt("R8 coincident write deferred", o, 10);
    runLine(40, o, p, v);
    cnt("R8 coincident write later", o, 2);

    // R3: zero width
    wr(3'd1, 8'd0);
    runLine(40, o, p, v);
    runLine(40, o, p, v);
    cnt("R3 zero width", o, 0);

    // R6: other panel type gates everything
    wr(3'd1, 8'd4);
    runLine(40, o, p, v);
    panelType = 2'b01;
    @(negedge clk);
    cnt("R6 clkEn gated", clkEnOut, 0);
    runLine(40, o, p, v);
    cnt("R6 oe gated", o + p + v, 0);
    panelType = 2'b10;
    runLine(40, o, p, v);
    cnt("R6 oe resumes", o, 8);

    // R3 R4: extreme positions
    wr(3'd0, 8'd255); wr(3'd1, 8'd255); wr(3'd2, 8'd255); wr(3'd3, 8'd200);
    runLine(20, o, p, v);
    runLine(1030, o, p, v);
    cnt("R3 max width", o, 510);
    cnt("R4 pol at max pos", p, 1);
    cnt("R5 vcom independent", v, 1);

    wr(3'd4, 8'd0);
    @(negedge clk);
    cnt("R7 clkEn cleared", clkEnOut, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule